// File: doc/BRIEF.md
# Fault-Checked Reversible Carry-Skip Adder

This block adds two small unsigned operands and an incoming carry using only models of parity-preserving reversible gates. A chain of five-input full-adder gates, with two inputs held at zero, forms the ripple carry path. Beside it, a skip network of controlled-swap gates, each used as an AND element, forms the group propagate and then selects the carry-out. When every bit position propagates, the incoming carry goes straight to the carry-out and the ripple chain's own carry is not used.

The incoming carry is needed both at the bottom of the ripple chain and at the carry-out selector. A double-XOR gate with two zero inputs makes the two copies, so no wire is split. The carry-out selector needs no OR. Its two product terms can never both be one, so one controlled-swap gate forms their exclusive-OR directly.

Every gate checks that the parity of its inputs equals the parity of its outputs, and any mismatch raises an error flag. A fault-injection port inverts one chosen gate output, and the flipped value propagates downstream as a real fault would. This lets the error flag and the skip path be tested from the block's ports.

Top module: `rpp_csk_adder`

## Requirements
- R1: With injection off, {cout, sum} equals a + b + cin for every combination of inputs.
- R2: Bit i propagates when a[i] XOR b[i] is 1. The group skips only when all W bits propagate.
- R3: When the group skips, cout equals cin as delivered by the fan-out gate's skip copy. A fault on the last ripple carry (site 5*(W-1)+3, which is 18 for W=4) then leaves cout unchanged.
- R4: When the group does not skip, cout is the last ripple carry. A fault at that carry site then inverts cout.
- R5: With injection off, par_err is 0.
- R6: With fi_en high and fi_sel below 8*W+3, exactly one gate output is inverted and par_err is 1.
- R7: Sites are numbered as follows. Full adder i has sites 5i+j, where j is 0 for the passed-through a, 1 for the propagate, 2 for the sum, 3 for the carry and 4 for the garbage output. The fan-out gate has site 5W (the copy to the ripple chain), 5W+1 (the copy to the carry selector) and 5W+2 (garbage). The AND gates and then the carry selector follow, three sites each, and the selector's site 1 drives cout. A select of 8*W+3 or above, or fi_en low, changes no output.
- R8: A fault at site 5i+2 inverts sum[i] and no other output bit.
- R9: A fault at site 5W makes sum equal the low W bits of a + b + (NOT cin). A fault at site 5W+1 makes cout equal NOT cin while the group skips, and has no effect on cout otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a | input | W | First operand |
| b | input | W | Second operand |
| cin | input | 1 | Incoming carry |
| fi_en | input | 1 | Enables single-site fault injection |
| fi_sel | input | $clog2(8W+3) | Gate-output site to invert |
| sum | output | W | Sum bits |
| cout | output | 1 | Carry-out from the skip selector |
| par_err | output | 1 | High when any gate's input parity differs from its output parity |

## Verification
The skip decision and a corrupted ripple carry can occur together. With a XOR b all ones, the ripple carry site is faulted. The bench then checks that cout still follows cin while par_err rises. This shows the skip path masks the bad carry from the output but not from the parity check. The same fault is swept across all operand pairs. cout must flip exactly when the group does not skip, and that flip pattern is computed in the bench from the XOR of the operands.

// File: rtl/rpp_pkg.sv
package rpp_pkg;

  // Five-input full-adder gate with two constant inputs (d, e).
  // Output order: {garb, carry, sum, prop, pass_a} as bits [4:0].
  function automatic logic [4:0] fa_gate(input logic a, input logic b,
                                         input logic c, input logic d,
                                         input logic e);
    logic q;
    logic s;
    logic k;
    q = a ^ b;
    s = q ^ c;
    k = (q & c) ^ (a & b) ^ d;
    return {b ^ e ^ k, k, s, q, a};
  endfunction

  // Controlled swap: bit0 = a, bit1 = a'b ^ ac, bit2 = a'c ^ ab.
  function automatic logic [2:0] cswap_gate(input logic a, input logic b,
                                            input logic c);
    logic o1;
    logic o2;
    o1 = (~a & b) ^ (a & c);
    o2 = (~a & c) ^ (a & b);
    return {o2, o1, a};
  endfunction

  // Double XOR: bit0 = a, bit1 = a ^ b, bit2 = a ^ c.
  function automatic logic [2:0] dxor_gate(input logic a, input logic b,
                                           input logic c);
    return {a ^ c, a ^ b, a};
  endfunction

  function automatic int site_count(input int w);
    return 8 * w + 3;
  endfunction

endpackage

// File: rtl/rpp_fa_cell.sv
module rpp_fa_cell (
  input  logic       a,
  input  logic       b,
  input  logic       c,
  input  logic [4:0] flip,
  output logic       prop,
  output logic       sum,
  output logic       carry,
  output logic       bad
);
  import rpp_pkg::*;

  logic [4:0] raw;
  logic [4:0] outv;
  logic       in_par;

  always_comb begin
    raw    = fa_gate(a, b, c, 1'b0, 1'b0);
    outv   = raw ^ flip;
    in_par = a ^ b ^ c;
    bad    = in_par ^ (^outv);
    prop   = outv[1];
    sum    = outv[2];
    carry  = outv[3];
  end
endmodule

// File: rtl/rpp_cswap_cell.sv
module rpp_cswap_cell #(
  parameter int PICK = 2
) (
  input  logic       a,
  input  logic       b,
  input  logic       c,
  input  logic [2:0] flip,
  output logic       y,
  output logic       bad
);
  import rpp_pkg::*;

  logic [2:0] outv;

  always_comb begin
    outv = cswap_gate(a, b, c) ^ flip;
    bad  = (a ^ b ^ c) ^ (^outv);
    y    = outv[PICK];
  end
endmodule

// File: rtl/rpp_fanout_cell.sv
module rpp_fanout_cell (
  input  logic       a,
  input  logic [2:0] flip,
  output logic       y0,
  output logic       y1,
  output logic       bad
);
  import rpp_pkg::*;

  logic [2:0] outv;

  always_comb begin
    outv = dxor_gate(a, 1'b0, 1'b0) ^ flip;
    bad  = a ^ (^outv);
    y0   = outv[0];
    y1   = outv[1];
  end
endmodule

// File: rtl/rpp_csk_adder.sv
module rpp_csk_adder #(
  parameter int W      = 4,
  parameter int NSITE  = 8 * W + 3,
  parameter int SITE_W = $clog2(NSITE)
) (
  input  logic [W-1:0]      a,
  input  logic [W-1:0]      b,
  input  logic              cin,
  input  logic              fi_en,
  input  logic [SITE_W-1:0] fi_sel,
  output logic [W-1:0]      sum,
  output logic              cout,
  output logic              par_err
);
  localparam int FAN_BASE = 5 * W;
  localparam int AND_BASE = FAN_BASE + 3;
  localparam int MUX_BASE = AND_BASE + 3 * (W - 1);
  localparam int NGATE    = W + 1 + (W - 1) + 1;

  logic [NSITE-1:0] flt;
  logic [NGATE-1:0] bad;
  logic [W:0]       rc;
  logic [W-1:0]     prop;
  logic [W-2:0]     and_ch;
  logic             cin_rip;
  logic             cin_skip;
  logic             skip_all;
  logic             ripple_c;

  always_comb begin
    for (int s = 0; s < NSITE; s++) begin
      flt[s] = fi_en && (fi_sel == SITE_W'(s));
    end
  end

  rpp_fanout_cell u_fan (
    .a    (cin),
    .flip (flt[FAN_BASE +: 3]),
    .y0   (cin_rip),
    .y1   (cin_skip),
    .bad  (bad[W])
  );

  assign rc[0] = cin_rip;

  generate
    for (genvar i = 0; i < W; i++) begin : g_fa
      rpp_fa_cell u_fa (
        .a     (a[i]),
        .b     (b[i]),
        .c     (rc[i]),
        .flip  (flt[5*i +: 5]),
        .prop  (prop[i]),
        .sum   (sum[i]),
        .carry (rc[i+1]),
        .bad   (bad[i])
      );
    end

    for (genvar k = 0; k < W - 1; k++) begin : g_and
      logic lhs;
      if (k == 0) begin : g_first
        assign lhs = prop[0];
      end else begin : g_next
        assign lhs = and_ch[k-1];
      end
      rpp_cswap_cell #(.PICK(2)) u_and (
        .a    (lhs),
        .b    (prop[k+1]),
        .c    (1'b0),
        .flip (flt[AND_BASE + 3*k +: 3]),
        .y    (and_ch[k]),
        .bad  (bad[W + 1 + k])
      );
    end
  endgenerate

  assign skip_all = and_ch[W-2];
  assign ripple_c = rc[W];

  rpp_cswap_cell #(.PICK(1)) u_mux (
    .a    (skip_all),
    .b    (ripple_c),
    .c    (cin_skip),
    .flip (flt[MUX_BASE +: 3]),
    .y    (cout),
    .bad  (bad[NGATE-1])
  );

  assign par_err = |bad;

endmodule

// File: rtl/rpp_csk_chk.sv
module rpp_csk_chk #(
  parameter int W      = 4,
  parameter int NSITE  = 8 * W + 3,
  parameter int SITE_W = $clog2(NSITE)
) (
  input logic [W-1:0]      a,
  input logic [W-1:0]      b,
  input logic              cin,
  input logic              fi_en,
  input logic [SITE_W-1:0] fi_sel,
  input logic [W-1:0]      sum,
  input logic              cout,
  input logic              par_err,
  input logic              skip_all,
  input logic              ripple_c
);
  logic [W:0] ref_total;
  logic       in_range;

  always_comb begin
    ref_total = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
    in_range  = int'(fi_sel) < NSITE;
    p_add_ok_r1: assert (fi_en || ({cout, sum} == ref_total))
      else $error("R1 sum mismatch");
    p_skip_full_r2: assert (fi_en || (skip_all == (&(a ^ b))))
      else $error("R2 skip decision wrong");
    p_skip_cin_r3: assert (fi_en || !skip_all || (cout == cin && ripple_c == cin))
      else $error("R3 skip path wrong");
    p_ripple_r4: assert (fi_en || skip_all || (cout == ripple_c))
      else $error("R4 ripple carry not selected");
    p_quiet_r5: assert (fi_en || !par_err)
      else $error("R5 spurious parity error");
    p_flag_r6: assert (!(fi_en && in_range) || par_err)
      else $error("R6 injected fault missed");
    p_oob_r7: assert (!(fi_en && !in_range) || (!par_err && {cout, sum} == ref_total))
      else $error("R7 out-of-range select had effect");
  end
endmodule

bind rpp_csk_adder rpp_csk_chk #(.W(W), .NSITE(NSITE), .SITE_W(SITE_W)) u_chk (
  .a        (a),
  .b        (b),
  .cin      (cin),
  .fi_en    (fi_en),
  .fi_sel   (fi_sel),
  .sum      (sum),
  .cout     (cout),
  .par_err  (par_err),
  .skip_all (skip_all),
  .ripple_c (ripple_c)
);

// File: tb/tb_rpp_csk_adder.sv
module tb_rpp_csk_adder;
  localparam int W      = 4;
  localparam int NSITE  = 8 * W + 3;
  localparam int SITE_W = $clog2(NSITE);
  localparam int CSITE  = 5 * (W - 1) + 3;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [W-1:0]      a = '0;
  logic [W-1:0]      b = '0;
  logic              cin = 1'b0;
  logic              fi_en = 1'b0;
  logic [SITE_W-1:0] fi_sel = '0;
  logic [W-1:0]      sum;
  logic              cout;
  logic              par_err;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  rpp_csk_adder #(.W(W)) dut (
    .a(a), .b(b), .cin(cin), .fi_en(fi_en), .fi_sel(fi_sel),
    .sum(sum), .cout(cout), .par_err(par_err)
  );

  task automatic drive(input int va, input int vb, input int vc,
                       input int en, input int sel);
    @(posedge clk);
    a      = W'(va);
    b      = W'(vb);
    cin    = vc[0];
    fi_en  = en[0];
    fi_sel = SITE_W'(sel);
    @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input int act,
                       input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int total(input int va, input int vb, input int vc);
    return va + vb + vc;
  endfunction

  function automatic bit all_prop(input int va, input int vb);
    return ((va ^ vb) & ((1 << W) - 1)) == ((1 << W) - 1);
  endfunction

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int got;
    int t;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // Quiet state: zero operands, no injection (R1, R5)
    drive(0, 0, 0, 0, 0);
    check({cout, sum} == 0, "R1 idle", int'({cout, sum}), 0);
    check(par_err == 1'b0, "R5 idle", int'(par_err), 0);

    // R1 / R5: exhaustive fault-free sweep
    for (int va = 0; va < (1 << W); va++)
      for (int vb = 0; vb < (1 << W); vb++)
        for (int vc = 0; vc < 2; vc++) begin
          drive(va, vb, vc, 0, 0);
          got = int'({cout, sum});
          t = total(va, vb, vc);
          check(got == t, "R1", got, t);
          check(par_err == 1'b0, "R5", int'(par_err), 0);
        end

    // R2/R3/R4: fault on last ripple carry over all operand pairs
    for (int va = 0; va < (1 << W); va++)
      for (int vb = 0; vb < (1 << W); vb++)
        for (int vc = 0; vc < 2; vc++) begin
          int exp_c;
          drive(va, vb, vc, 1, CSITE);
          t = total(va, vb, vc);
          if (all_prop(va, vb)) begin
            exp_c = vc;
            check(cout == exp_c[0], "R3 skip masks ripple fault (R2)", int'(cout), exp_c);
          end else begin
            exp_c = ((t >> W) & 1) ^ 1;
            check(cout == exp_c[0], "R4 ripple fault reaches cout (R2)", int'(cout), exp_c);
          end
          check(int'(sum) == (t & ((1 << W) - 1)), "R3 sum intact", int'(sum), t & ((1 << W) - 1));
          check(par_err == 1'b1, "R6 carry fault flagged", int'(par_err), 1);
        end

    // R6: every site flags, on several operand patterns
    for (int s = 0; s < NSITE; s++) begin
      drive(5, 10, 1, 1, s);
      check(par_err == 1'b1, "R6 all-propagate", int'(par_err), 1);
      drive(3, 6, 0, 1, s);
      check(par_err == 1'b1, "R6 mixed", int'(par_err), 1);
      drive(15, 15, 1, 1, s);
      check(par_err == 1'b1, "R6 generate", int'(par_err), 1);
    end

    // R7: out-of-range selects and disabled injection change nothing
    for (int s = NSITE; s < (1 << SITE_W); s++) begin
      drive(9, 7, 1, 1, s);
      got = int'({cout, sum});
      check(got == total(9, 7, 1) && !par_err, "R7 out of range", got, total(9, 7, 1));
    end
    drive(12, 3, 1, 0, CSITE);
    got = int'({cout, sum});
    check(got == total(12, 3, 1) && !par_err, "R7 disabled", got, total(12, 3, 1));

    // R8: sum-site faults invert one sum bit
    for (int i = 0; i < W; i++)
      for (int va = 0; va < (1 << W); va += 3) begin
        int e;
        drive(va, 6, 1, 1, 5 * i + 2);
        e = total(va, 6, 1) ^ (1 << i);
        got = int'({cout, sum});
        check(got == e, "R8 sum bit flip", got, e);
      end

    // R9: fan-out copies
    for (int va = 0; va < (1 << W); va++)
      for (int vc = 0; vc < 2; vc++) begin
        int e;
        drive(va, 5, vc, 1, 5 * W);
        e = total(va, 5, vc ^ 1) & ((1 << W) - 1);
        check(int'(sum) == e, "R9 ripple copy fault", int'(sum), e);
        drive(va, 5, vc, 1, 5 * W + 1);
        if (all_prop(va, 5)) e = vc ^ 1;
        else e = (total(va, 5, vc) >> W) & 1;
        check(int'(cout) == e, "R9 skip copy fault", int'(cout), e);
      end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule